// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Logic

This block turns the debounced level of each general-purpose pin into a sticky interrupt status flag and a per-pin interrupt request. Each pin has its own settings. A mode bit picks edge or level detection. A 2-bit polarity field picks low or falling, high or rising, or both edges. An enable bit arms detection. An unmask bit lets a set flag drive the request line. A wake-enable bit lets the same trigger event set a separate wake flag.

Software reads the flags and clears them by writing them back as ones, which shows up here as a one-cycle clear strobe for each pin. A pin is pending while either flag is set. Combining requests across pins is left to the logic that surrounds this block. The number of pins is a parameter, and every pin is an independent copy of the same cell.

Top module: `gpio_irq_trigger`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every interrupt flag, wake flag, pending bit and request is 0.
- R2: In edge mode (mode bit 0), polarity 2'b01 sets the interrupt flag on a rising pin level. Polarity 2'b00 sets it on a falling level, and 2'b10 sets it on either edge. The flag is visible one clock after the edge is sampled.
- R3: Polarity 2'b11 never sets either flag in either mode. In level mode, polarity 2'b10 also never sets a flag.
- R4: In level mode (mode bit 1), polarity 2'b00 sets the flag in every cycle the pin is low, and 2'b01 sets it in every cycle the pin is high. A clear that comes while the level is still active leaves the flag set.
- R5: While the enable bit is 0, the interrupt flag is never set by the pin, and it changes only when a clear strobe arrives.
- R6: Both flags are sticky. A clear strobe for a pin clears both its interrupt flag and its wake flag in the next cycle, unless R7 or R4 applies.
- R7: A trigger event in the same cycle as a clear strobe wins, so the flag it would set stays set.
- R8: The request for a pin is 1 only when the pin is pending and both its enable bit and its unmask bit are 1. Masking (unmask 0) does not stop the flags from latching.
- R9: A pin is pending exactly when its interrupt flag or its wake flag is set.
- R10: When the wake-enable bit is 1, a trigger event sets the wake flag, whatever the enable bit is.
- R11: In the first cycle after reset, the pin level is only captured as the reference. A pin that is already high at that point is not seen as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NPINS | Debounced pin levels |
| cfg_lvl_mode | input | NPINS | Per pin: 1 level-triggered, 0 edge-triggered |
| cfg_act | input | 2*NPINS | Per pin polarity field, pin i at bits [2i+1:2i] |
| cfg_en | input | NPINS | Per pin detection enable |
| cfg_unmask | input | NPINS | Per pin: 1 lets a pending pin raise its request |
| cfg_wake_en | input | NPINS | Per pin wake flag enable |
| clr_sts | input | NPINS | Per pin one-cycle clear strobe for both flags |
| int_sts | output | NPINS | Interrupt flags |
| wake_sts | output | NPINS | Wake flags |
| pending | output | NPINS | Interrupt or wake flag set |
| irq_req | output | NPINS | Per pin interrupt request |

## Verification
Faults in this block show up at the ports quickly. A stale level reference produces a false or missing flag one clock after the edge in question. A wrong polarity decode shows up as a flag on the wrong edge, or as a flag for the reserved code. Flags that should hold but drift, or a clear that wins over a same-cycle event, are visible in the very next cycle. Because the request is combinational from the flags and the settings, a gating error shows up in the same cycle that the settings change.

// File: rtl/gpio_irq_pkg.sv
// Shared types for the pin interrupt trigger logic.
// Assumes the polarity field is 2 bits wide and uses the encoding below.
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        ACT_LOW  = 2'b00,
        ACT_HIGH = 2'b01,
        ACT_BOTH = 2'b10,
        ACT_RSVD = 2'b11
    } act_e;

    localparam int ACT_W = 2;
endpackage

// File: rtl/gpio_irq_edge.sv
// Keeps the previous sample of one debounced pin and reports rising and
// falling transitions. Assumes pin is already synchronous to clk.
// No edge is reported until a first reference sample has been taken.
module gpio_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic prev_q;
    logic primed_q;

    // Capture the reference level and mark it valid after the first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin;
            primed_q <= 1'b1;
        end
    end

    // Compare the live level with the reference.
    always_comb begin
        rise = primed_q &  pin & ~prev_q;
        fall = primed_q & ~pin &  prev_q;
    end
endmodule

// File: rtl/gpio_irq_match.sv
// Decides whether the current cycle is a trigger event for one pin, from
// the mode bit, the polarity field, the live level and the edge strobes.
// Purely combinational; the reserved polarity never matches.
module gpio_irq_match
    import gpio_irq_pkg::*;
(
    input  logic             lvl_mode,
    input  logic [ACT_W-1:0] act,
    input  logic             pin,
    input  logic             rise,
    input  logic             fall,
    output logic             hit
);
    act_e act_sel;

    // Select the event source for the configured mode and polarity.
    always_comb begin
        act_sel = act_e'(act);
        hit     = 1'b0;
        if (lvl_mode) begin
            unique case (act_sel)
                ACT_LOW:  hit = ~pin;
                ACT_HIGH: hit = pin;
                default:  hit = 1'b0;
            endcase
        end else begin
            unique case (act_sel)
                ACT_LOW:  hit = fall;
                ACT_HIGH: hit = rise;
                ACT_BOTH: hit = rise | fall;
                default:  hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_cell.sv
// One pin: edge tracking, event decode and the two sticky flags.
// Assumes clr is a single-cycle write-one-to-clear strobe.
// A same-cycle trigger event takes priority over the clear.
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             lvl_mode,
    input  logic [ACT_W-1:0] act,
    input  logic             int_en,
    input  logic             wake_en,
    input  logic             clr,
    output logic             int_sts,
    output logic             wake_sts
);
    logic rise;
    logic fall;
    logic hit;
    logic int_q;
    logic wake_q;

    gpio_irq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin),
        .rise  (rise),
        .fall  (fall)
    );

    gpio_irq_match u_match (
        .lvl_mode (lvl_mode),
        .act      (act),
        .pin      (pin),
        .rise     (rise),
        .fall     (fall),
        .hit      (hit)
    );

    // Interrupt flag: set on an enabled event, else cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            int_q <= 1'b0;
        else if (int_en && hit) int_q <= 1'b1;
        else if (clr)           int_q <= 1'b0;
    end

    // Wake flag: set on an event when wake is enabled, else cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              wake_q <= 1'b0;
        else if (wake_en && hit) wake_q <= 1'b1;
        else if (clr)            wake_q <= 1'b0;
    end

    assign int_sts  = int_q;
    assign wake_sts = wake_q;

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && hit) |=> int_q);

    // R3
    rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act == ACT_RSVD || (lvl_mode && act == ACT_BOTH)) && !int_q && !wake_q)
        |=> (!int_q && !wake_q));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && !clr) |=> $stable(int_q));

    // R6
    clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> (!int_q && !wake_q));

    // R10
    wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && hit) |=> wake_q);
endmodule

// File: rtl/gpio_irq_trigger.sv
// Per-pin interrupt trigger logic for NPINS independent pins. Each pin
// latches interrupt and wake flags and raises its own request when
// pending, enabled and unmasked. Pins are not combined here.
// Assumes all inputs are synchronous to clk.
module gpio_irq_trigger
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_lvl,
    input  logic [NPINS-1:0]       cfg_lvl_mode,
    input  logic [ACT_W*NPINS-1:0] cfg_act,
    input  logic [NPINS-1:0]       cfg_en,
    input  logic [NPINS-1:0]       cfg_unmask,
    input  logic [NPINS-1:0]       cfg_wake_en,
    input  logic [NPINS-1:0]       clr_sts,
    output logic [NPINS-1:0]       int_sts,
    output logic [NPINS-1:0]       wake_sts,
    output logic [NPINS-1:0]       pending,
    output logic [NPINS-1:0]       irq_req
);
    // One cell per pin.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_lvl[i]),
            .lvl_mode (cfg_lvl_mode[i]),
            .act      (cfg_act[ACT_W*i +: ACT_W]),
            .int_en   (cfg_en[i]),
            .wake_en  (cfg_wake_en[i]),
            .clr      (clr_sts[i]),
            .int_sts  (int_sts[i]),
            .wake_sts (wake_sts[i])
        );
    end

    // Pending merges both flags; the request also needs enable and unmask.
    always_comb begin
        pending = int_sts | wake_sts;
        irq_req = pending & cfg_en & cfg_unmask;
    end
endmodule

// File: tb/gpio_irq_trigger_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_trigger_tb_top;
    localparam int NPINS = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NPINS-1:0]   pin_lvl = '0;
    logic [NPINS-1:0]   cfg_lvl_mode = '0;
    logic [2*NPINS-1:0] cfg_act = '0;
    logic [NPINS-1:0]   cfg_en = '0;
    logic [NPINS-1:0]   cfg_unmask = '0;
    logic [NPINS-1:0]   cfg_wake_en = '0;
    logic [NPINS-1:0]   clr_sts = '0;
    logic [NPINS-1:0]   int_sts, wake_sts, pending, irq_req;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [NPINS-1:0] m_prev = '0, m_vld = '0, m_int = '0, m_wake = '0;

    always #2.5 clk = ~clk;

    gpio_irq_trigger #(.NPINS(NPINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_lvl_mode(cfg_lvl_mode),
        .cfg_act(cfg_act), .cfg_en(cfg_en), .cfg_unmask(cfg_unmask),
        .cfg_wake_en(cfg_wake_en), .clr_sts(clr_sts), .int_sts(int_sts),
        .wake_sts(wake_sts), .pending(pending), .irq_req(irq_req)
    );

    function automatic logic f_hit(logic lvl, logic [1:0] act, logic p, logic prv, logic vld);
        logic r, f;
        r = vld & p & ~prv;
        f = vld & ~p & prv;
        if (lvl) return (act == 2'b00) ? ~p : (act == 2'b01) ? p : 1'b0;
        case (act)
            2'b00:   return f;
            2'b01:   return r;
            2'b10:   return r | f;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [NPINS-1:0] act, logic [NPINS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock, update the model, compare every output at negedge.
    task automatic step();
        @(posedge clk);
        #1;
        for (int i = 0; i < NPINS; i++) begin
            if (!rst_n) begin
                m_prev[i] = 0; m_vld[i] = 0; m_int[i] = 0; m_wake[i] = 0;
            end else begin
                logic h;
                h = f_hit(cfg_lvl_mode[i], cfg_act[2*i +: 2], pin_lvl[i], m_prev[i], m_vld[i]);
                if (cfg_en[i] && h) m_int[i] = 1; else if (clr_sts[i]) m_int[i] = 0;
                if (cfg_wake_en[i] && h) m_wake[i] = 1; else if (clr_sts[i]) m_wake[i] = 0;
                m_prev[i] = pin_lvl[i];
                m_vld[i]  = 1;
            end
        end
        @(negedge clk);
        chk("R2 int_sts", int_sts, m_int);
        chk("R10 wake_sts", wake_sts, m_wake);
        chk("R9 pending", pending, m_int | m_wake);
        chk("R8 irq_req", irq_req, (m_int | m_wake) & cfg_en & cfg_unmask);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        // R1: reset values with a pin held high
        pin_lvl = 4'b0001;
        cfg_act[1:0] = 2'b01; cfg_en[0] = 1; cfg_unmask[0] = 1;
        step(); step();
        chk("R1 reset int", int_sts, '0);
        chk("R1 reset req", irq_req, '0);
        rst_n = 1;
        // R11: first sample after reset is reference only
        step();
        chk("R11 no edge at start", int_sts, '0);
        // R2: falling then rising edge
        pin_lvl[0] = 0; step();
        chk("R2 no flag on fall", int_sts[0], 1'b0);
        pin_lvl[0] = 1; step();
        chk("R2 rise sets", int_sts[0], 1'b1);
        chk("R8 req raised", irq_req[0], 1'b1);
        // R8: masked, flag kept
        cfg_unmask[0] = 0; step();
        chk("R8 masked req", irq_req[0], 1'b0);
        chk("R8 masked flag kept", int_sts[0], 1'b1);
        // R6: clear
        clr_sts[0] = 1; step(); clr_sts[0] = 0;
        chk("R6 cleared", int_sts[0], 1'b0);
        // R8: masked pin still latches
        pin_lvl[0] = 0; step();
        pin_lvl[0] = 1; step();
        chk("R8 latch while masked", int_sts[0], 1'b1);
        cfg_unmask[0] = 1;
        clr_sts[0] = 1; step(); clr_sts[0] = 0;
        // R7: edge and clear in same cycle
        pin_lvl[0] = 0; step();
        pin_lvl[0] = 1; clr_sts[0] = 1; step(); clr_sts[0] = 0;
        chk("R7 edge beats clear", int_sts[0], 1'b1);
        clr_sts[0] = 1; step(); clr_sts[0] = 0;
        // R3: reserved code, edge mode
        cfg_act[1:0] = 2'b11;
        for (int k = 0; k < 4; k++) begin pin_lvl[0] = ~pin_lvl[0]; step(); end
        chk("R3 reserved edge", int_sts[0], 1'b0);
        // R3: both-edges code in level mode
        cfg_lvl_mode[0] = 1; cfg_act[1:0] = 2'b10; pin_lvl[0] = 1; step(); step();
        chk("R3 level both silent", int_sts[0], 1'b0);
        // R4: level high, clear while active
        cfg_act[1:0] = 2'b01; step();
        chk("R4 level sets", int_sts[0], 1'b1);
        clr_sts[0] = 1; step();
        chk("R4 level re-sets", int_sts[0], 1'b1);
        pin_lvl[0] = 0; step(); clr_sts[0] = 0;
        chk("R6 clear after level drop", int_sts[0], 1'b0);
        // R4: level low
        cfg_act[1:0] = 2'b00; step();
        chk("R4 level low sets", int_sts[0], 1'b1);
        clr_sts[0] = 1; pin_lvl[0] = 1; step(); clr_sts[0] = 0;
        // R5: disabled level
        cfg_en[0] = 0; cfg_act[1:0] = 2'b01; step(); step();
        chk("R5 disabled no flag", int_sts[0], 1'b0);
        // R10: wake with enable off, request held low
        cfg_lvl_mode[0] = 0; cfg_wake_en[0] = 1; pin_lvl[0] = 0; step();
        pin_lvl[0] = 1; step();
        chk("R10 wake set", wake_sts[0], 1'b1);
        chk("R9 pending from wake", pending[0], 1'b1);
        chk("R8 no req when disabled", irq_req[0], 1'b0);
        clr_sts[0] = 1; step(); clr_sts[0] = 0;
        chk("R6 wake cleared", wake_sts[0], 1'b0);
        // Random phase
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NPINS; i++) begin
                if ($urandom_range(3) == 0) pin_lvl[i] = ~pin_lvl[i];
                clr_sts[i] = ($urandom_range(7) == 0);
                if ($urandom_range(31) == 0) begin
                    cfg_lvl_mode[i] = 1'($urandom_range(1));
                    cfg_act[2*i +: 2] = 2'($urandom_range(3));
                    cfg_en[i] = 1'($urandom_range(1));
                    cfg_unmask[i] = 1'($urandom_range(1));
                    cfg_wake_en[i] = 1'($urandom_range(1));
                end
            end
            if (c == 1500) rst_n = 0;
            if (c == 1503) rst_n = 1;
            step();
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule